// File: doc/BRIEF.md
# Parallel Port Host Control Register

This block holds the control word that a CPU writes to run the host side of a parallel printer-style port. The stored bits drive four active-low handshake outputs: strobe, auto-feed, init and select-in. The polarity of each pin is fixed so that an all-zero word leaves the port idle and ready. Another bit sets the direction of the 8-bit data bus. With that bit clear the host drives the bus for forward transfers. With it set the bus is released so the peripheral can drive it for reverse transfers.

The block also watches the acknowledge input from the peripheral. The input is resynchronised to the local clock. When the interrupt enable bit is set, a low-to-high transition on acknowledge sets a sticky pending flag, and that flag is the interrupt request. Software clears the flag by writing a one to it. The transfer-mode sequencers and the data FIFO sit outside this block and only use its outputs.

Top module: `parallel_port_ctrl`

## Requirements
- R1: After reset the control word reads 0x00. The pins are then select-in high, init low, auto-feed high and strobe high. The data bus output enable is 1 and the interrupt request is 0.
- R2: The control word lives at address 0. Strobe output = NOT bit 0, auto-feed output = NOT bit 1, and select-in output = NOT bit 3.
- R3: The init output equals bit 2 of the control word, with no inversion.
- R4: The data bus output enable is 1 when bit 5 is 0 (forward, host drives). It is 0 when bit 5 is 1 (reverse, peripheral drives).
- R5: A read of address 0 returns the stored bits 5..0, with bits 7..6 read as zero. The value does not depend on pin or acknowledge activity. A write takes effect on the clock edge at which it is presented.
- R6: With bit 4 (interrupt enable) set, a rising edge on the acknowledge input sets the pending flag. The change of acknowledge happens before clock edge k, and the interrupt request rises after edge k+2, that is, at the third edge.
- R7: A falling edge or a steady level on acknowledge never raises the interrupt request.
- R8: A rising edge on acknowledge that is synchronised while bit 4 is 0 is ignored. No interrupt request follows, and the flag does not rise later when the enable is set.
- R9: The pending flag is bit 0 of address 1. It stays set until a write to address 1 with data bit 0 = 1. Writing 0 there leaves it set. Clearing bit 4 does not clear it.
- R10: If a new acknowledge edge and a clearing write meet in the same cycle, the flag stays set.
- R11: Writes to address 1 or to the unused addresses 2 and 3 leave the control word unchanged. Those unused addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address (0 control, 1 status) |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| strobe_n_o | output | 1 | Active-low strobe pin |
| autofd_n_o | output | 1 | Active-low auto-feed pin |
| init_n_o | output | 1 | Active-low init pin |
| selin_n_o | output | 1 | Active-low select-in pin |
| data_oe_o | output | 1 | Data bus output enable (1 = host drives) |
| ack_i | input | 1 | Asynchronous acknowledge from the peripheral |
| irq_o | output | 1 | Interrupt request (sticky pending flag) |

## Verification
The bench sweeps all 64 control words. That exposes any pin that carries the wrong polarity, and in particular an init pin that is inverted like its neighbours would fail the reset idle check. The interrupt tests target edge detection. A level-sensitive or falling-edge detector would raise the request while acknowledge is held or falls. An edge masked at the synchroniser stage could leak through once the enable is turned on late. A design that gives the clearing write priority over a coinciding edge would drop an interrupt. Stray writes to the status and unused addresses are checked for corrupting the control word.

// File: rtl/ppc_pkg.sv
// Shared constants for the parallel port control register.
// Assumes an 8-bit register bus and a 6-bit control word.
package ppc_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int CTRL_W   = 6;
    // Bit positions inside the control word
    localparam int B_STROBE = 0;
    localparam int B_AUTOFD = 1;
    localparam int B_INIT   = 2;
    localparam int B_SELIN  = 3;
    localparam int B_ACKEN  = 4;
    localparam int B_DIR    = 5;
    // Register addresses
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
endpackage

// File: rtl/ppc_ctrl_reg.sv
// Control word storage. Captures a write to the control address on the
// clock edge and holds it. Assumes a single-cycle write strobe.
module ppc_ctrl_reg
    import ppc_pkg::*;
#(
    parameter int W = CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      ctrl_q
);
    // Hold the control word; all-zero reset is the idle port state
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (wr_en)  ctrl_q <= wdata;
    end
endmodule

// File: rtl/ppc_pin_map.sv
// Maps control bits onto pin levels with fixed per-pin polarity.
// Pure combinational; assumes the bit layout in ppc_pkg.
module ppc_pin_map
    import ppc_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output logic              strobe_n,
    output logic              autofd_n,
    output logic              init_n,
    output logic              selin_n,
    output logic              data_oe
);
    // Drive pins: init passes straight, the others are inverted
    always_comb begin
        strobe_n = ~ctrl[B_STROBE];
        autofd_n = ~ctrl[B_AUTOFD];
        init_n   =  ctrl[B_INIT];
        selin_n  = ~ctrl[B_SELIN];
        data_oe  = ~ctrl[B_DIR];
    end
endmodule

// File: rtl/ppc_ack_irq.sv
// Synchronises the acknowledge input, detects its rising edge and keeps a
// sticky pending flag. The flag is set when the enable is on, and cleared
// by a write-one. A set in the same cycle as a clear wins. Assumes ack_i
// is asynchronous. Sync flops reset low, so an ack held high through
// reset looks like an edge, which the reset-clear enable masks.
module ppc_ack_irq #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    input  logic enable,
    input  logic clr,
    output logic pending
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // First synchroniser stage samples the raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= ack_i;
                end
            end else begin : g_rest
                // Later stages shift the sampled value along
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Remember the last synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

    // Sticky pending flag: set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)              pending <= 1'b0;
        else if (rise && enable) pending <= 1'b1;
        else if (clr)            pending <= 1'b0;
    end
endmodule

// File: rtl/parallel_port_ctrl.sv
// Top of the parallel port control register: register decode, control
// storage, pin mapping and acknowledge interrupt. Reads are combinational
// and return stored bits, never pin levels.
module parallel_port_ctrl
    import ppc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              strobe_n_o,
    output logic              autofd_n_o,
    output logic              init_n_o,
    output logic              selin_n_o,
    output logic              data_oe_o,
    input  logic              ack_i,
    output logic              irq_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              ctrl_wr;
    logic              stat_clr;
    logic              pending;

    assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
    assign stat_clr = reg_wr && (reg_addr == A_STAT) && reg_wdata[0];

    ppc_ctrl_reg #(.W(CTRL_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctrl_wr),
        .wdata  (reg_wdata[CTRL_W-1:0]),
        .ctrl_q (ctrl_q)
    );

    ppc_pin_map u_pins (
        .ctrl     (ctrl_q),
        .strobe_n (strobe_n_o),
        .autofd_n (autofd_n_o),
        .init_n   (init_n_o),
        .selin_n  (selin_n_o),
        .data_oe  (data_oe_o)
    );

    ppc_ack_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_i   (ack_i),
        .enable  (ctrl_q[B_ACKEN]),
        .clr     (stat_clr),
        .pending (pending)
    );

    assign irq_o = pending;

    // Read mux: stored control word, pending flag, zero elsewhere
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl_q;
            A_STAT:  reg_rdata[0]          = pending;
            default: reg_rdata             = '0;
        endcase
    end
endmodule

// File: rtl/parallel_port_ctrl_chk.sv
// Assertion checker for parallel_port_ctrl, attached with bind.
module parallel_port_ctrl_chk
    import ppc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              strobe_n_o,
    input logic              autofd_n_o,
    input logic              init_n_o,
    input logic              selin_n_o,
    input logic              data_oe_o,
    input logic              irq_o,
    input logic [CTRL_W-1:0] ctrl_q
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == '0 && !irq_o)); // R1
    AST_INV_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTRL) |-> (strobe_n_o != reg_rdata[0] && autofd_n_o != reg_rdata[1]
                                  && selin_n_o != reg_rdata[3])); // R2
    AST_INIT_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTRL) |-> (init_n_o == reg_rdata[2])); // R3
    AST_BUS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTRL) |-> (data_oe_o != reg_rdata[5])); // R4
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !ctrl_q[B_ACKEN]) |=> !irq_o); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(reg_wr && reg_addr == A_STAT && reg_wdata[0])) |=> irq_o); // R9
    AST_CTRL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != A_CTRL) |=> $stable(ctrl_q)); // R11
endmodule

bind parallel_port_ctrl parallel_port_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .strobe_n_o (strobe_n_o),
    .autofd_n_o (autofd_n_o),
    .init_n_o   (init_n_o),
    .selin_n_o  (selin_n_o),
    .data_oe_o  (data_oe_o),
    .irq_o      (irq_o),
    .ctrl_q     (ctrl_q)
);

// File: tb/parallel_port_ctrl_bench.sv
module parallel_port_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       strobe_n_o, autofd_n_o, init_n_o, selin_n_o, data_oe_o;
    logic       ack_i = 1'b0;
    logic       irq_o;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    parallel_port_ctrl u_parallel_port_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .strobe_n_o(strobe_n_o),
        .autofd_n_o(autofd_n_o), .init_n_o(init_n_o), .selin_n_o(selin_n_o),
        .data_oe_o(data_oe_o), .ack_i(ack_i), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive a one-cycle write; returns at the following negedge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    function automatic logic [7:0] pins_exp(input logic [5:0] v);
        return {3'b000, ~v[5], ~v[3], v[2], ~v[1], ~v[0]};
    endfunction

    function automatic logic [7:0] pins_act();
        return {3'b000, data_oe_o, selin_n_o, init_n_o, autofd_n_o, strobe_n_o};
    endfunction

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, d); check("R1 ctrl", d, 8'h00);
        check("R1 pins", pins_act(), 8'b0001_1011);
        check("R1 irq", {7'd0, irq_o}, 8'd0);

        // R2 R3 R4 R5 sweep of all control words, with ack toggling
        for (int v = 0; v < 64; v++) begin
            wr(2'd0, {2'b11, 6'(v)});
            ack_i = v[0];
            rd(2'd0, d);
            check("R5 readback", d, {2'b00, 6'(v)});
            check("R2/R3/R4 pins", pins_act(), pins_exp(6'(v)));
        end
        ack_i = 1'b0;
        wr(2'd1, 8'h01); cycles(3); wr(2'd1, 8'h01);

        // R11 writes to status and unused addresses leave ctrl alone
        wr(2'd0, 8'h2A);
        for (int a = 1; a < 4; a++) begin
            wr(2'(a), 8'h15);
            rd(2'd0, d); check("R11 ctrl kept", d, 8'h2A);
            if (a > 1) begin rd(2'(a), d); check("R11 unused reads 0", d, 8'h00); end
        end
        wr(2'd1, 8'h01);

        // R8 edge with enable off, then enable later
        wr(2'd0, 8'h00);
        ack_i = 1'b1; cycles(5);
        check("R8 masked edge", {7'd0, irq_o}, 8'd0);
        wr(2'd0, 8'h10); cycles(4);
        check("R8 no late irq", {7'd0, irq_o}, 8'd0);
        rd(2'd1, d); check("R8 status", d, 8'h00);

        // R7 falling edge and steady high do not raise irq
        ack_i = 1'b0; cycles(5);
        check("R7 fall", {7'd0, irq_o}, 8'd0);

        // R6 rising edge latency: irq after third edge
        ack_i = 1'b1;
        cycles(2); check("R6 not yet", {7'd0, irq_o}, 8'd0);
        cycles(1); check("R6 irq set", {7'd0, irq_o}, 8'd1);
        rd(2'd1, d); check("R6 status bit0", d, 8'h01);
        cycles(6); check("R7 steady high keeps only one", {7'd0, irq_o}, 8'd1);

        // R9 sticky: write 0 and disabling do not clear; write 1 does
        wr(2'd1, 8'hFE); check("R9 write0", {7'd0, irq_o}, 8'd1);
        wr(2'd0, 8'h00); check("R9 disable", {7'd0, irq_o}, 8'd1);
        wr(2'd1, 8'h01); check("R9 w1c", {7'd0, irq_o}, 8'd0);
        ack_i = 1'b0; cycles(4);
        check("R7 fall after clear", {7'd0, irq_o}, 8'd0);

        // R10 set coinciding with clear wins
        wr(2'd0, 8'h10);
        ack_i = 1'b1;              // before edge k
        cycles(2);                 // edges k, k+1
        wr(2'd1, 8'h01);           // write active at edge k+2
        check("R10 set wins", {7'd0, irq_o}, 8'd1);
        wr(2'd1, 8'h01);
        check("R10 later clear", {7'd0, irq_o}, 8'd0);

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule